// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a programmable sum-of-products device. It holds a row of output cells (eight by default), each receiving its own group of product terms from an AND array that sits outside the block. Each cell ORs its terms into a sum, sets the polarity, and then either drives the sum straight to its pin, stores it in a register and drives the register, or turns the pin into an input. The cell also returns a feedback bit to the array.

A single architecture word sets the whole bank. It has three parts. A block of per-term kill bits forces any chosen product term to zero. Two global control bits are shared by every cell. Each cell also has two control bits of its own. One global bit allows or forbids registers across the whole bank. Together with the second global bit and the cell's own mode bit, it selects one of five pin arrangements. A registered cell drives its pin only while a shared output-enable input is high.

Top module: `omc_bank`

## Requirements
- R1: Architecture bits [31:0] kill product terms 0..31 and bits [81:50] kill terms 32..63 (term k uses bit k+18). Term k belongs to cell k/8 at position k%8. A kill bit of 1 forces that term to 0 before any use.
- R2: Bit 32 is the global register-inhibit bit (G) and bit 33 is the global mode bit (M). Bit 34+n is the mode bit (A) of cell n. Bit 42+n is the polarity bit (P) of cell n.
- R3: P=1 passes a cell's sum unchanged. P=0 inverts the sum before it reaches the pin or the register.
- R4: With G,M,A = 1,0,1 the cell is an input. pin_oe=0, pin_out=0, and fbk follows pin_in.
- R5: With G,M,A = 1,0,0 the cell is a combinational output. pin_oe=1, pin_out is the polarity-adjusted OR of all eight terms, and fbk equals pin_out.
- R6: With G,M,A = 1,1,1 the cell is a combinational I/O. pin_oe equals term 0 after killing, pin_out is the polarity-adjusted OR of terms 1..7, and fbk follows pin_in.
- R7: With G,M,A = 0,1,0 the cell is registered. At each rising clock edge the register loads the polarity-adjusted OR of all eight terms. pin_out is the inverted register, pin_oe equals oe, and fbk is the register.
- R8: With G,M,A = 0,1,1 the cell behaves exactly as in R6.
- R9: Every other G,M,A combination (0,0,x and 1,1,0) behaves as the input mode of R4.
- R10: While rst_n is low every register is cleared, so a registered cell shows fbk=0 and pin_out=1.
- R11: With G=0, cells in registered mode and cells in the combinational I/O mode work side by side without affecting each other.
- R12: A cell's register loads only while that cell is in registered mode. In any other mode it keeps its value, which appears again when the cell returns to registered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell registers |
| rst_n | input | 1 | Asynchronous active-low reset of the cell registers |
| oe | input | 1 | Shared output enable for registered cells |
| terms | input | 64 | Product terms, eight per cell, cell n at [8n+7:8n] |
| pin_in | input | 8 | Value currently present on each pin |
| arch | input | 82 | Architecture word |
| pin_out | output | 8 | Value driven toward each pin |
| pin_oe | output | 8 | Driver enable for each pin |
| fbk | output | 8 | Feedback to the AND array |

## Verification
The bound checker reads the architecture word directly and checks the per-cell pin rules on every clock. In input and undecoded codes the driver is off and feedback follows the pin. A combinational output is always driven and feeds back its own value. A registered output drives the inverse of its feedback under the shared enable. I/O modes feed back the pin. Some behaviour can only be shown by the bench's scenarios against its reference model: what the register actually loads, the polarity choice, which term each kill bit reaches, the value held across a mode change, and the reset value.

// File: rtl/omc_pkg.sv
package omc_pkg;

   typedef enum logic [2:0] {
      CM_INPUT    = 3'd0,
      CM_COMB_OUT = 3'd1,
      CM_COMB_IO  = 3'd2,
      CM_REG_OUT  = 3'd3,
      CM_REG_IO   = 3'd4
   } cell_mode_e;

   // G = register inhibit, M = global mode, A = cell mode bit
   function automatic cell_mode_e decode_mode(input logic g, input logic m, input logic a);
      cell_mode_e res;
      case ({g, m, a})
         3'b101:  res = CM_INPUT;
         3'b100:  res = CM_COMB_OUT;
         3'b111:  res = CM_COMB_IO;
         3'b010:  res = CM_REG_OUT;
         3'b011:  res = CM_REG_IO;
         default: res = CM_INPUT;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/omc_cfg_split.sv
module omc_cfg_split #(
   parameter int NUM_CELLS      = 8,
   parameter int TERMS_PER_CELL = 8,
   parameter int KILL_HALF      = 32
) (
   input  logic [2*KILL_HALF+2+2*NUM_CELLS-1:0] arch,
   output logic [NUM_CELLS*TERMS_PER_CELL-1:0]  term_kill,
   output logic                                 g_inhibit,
   output logic                                 g_mode,
   output logic [NUM_CELLS-1:0]                 cell_mode_bit,
   output logic [NUM_CELLS-1:0]                 cell_pol
);
   localparam int CTRL_LO  = KILL_HALF;
   localparam int MODE_LO  = CTRL_LO + 2;
   localparam int POL_LO   = MODE_LO + NUM_CELLS;
   localparam int KILL_HI0 = POL_LO + NUM_CELLS;

   if (NUM_CELLS * TERMS_PER_CELL != 2 * KILL_HALF) begin : g_bad_kill_split
      $error("omc_cfg_split: kill bits must cover every product term");
   end

   assign term_kill     = {arch[KILL_HI0 +: KILL_HALF], arch[KILL_HALF-1:0]};
   assign g_inhibit     = arch[CTRL_LO];
   assign g_mode        = arch[CTRL_LO+1];
   assign cell_mode_bit = arch[MODE_LO +: NUM_CELLS];
   assign cell_pol      = arch[POL_LO +: NUM_CELLS];
endmodule

// File: rtl/omc_term_gate.sv
module omc_term_gate #(
   parameter int TERMS_PER_CELL = 8
) (
   input  logic [TERMS_PER_CELL-1:0] terms,
   input  logic [TERMS_PER_CELL-1:0] kill,
   output logic                      sum_all,
   output logic                      sum_tail,
   output logic                      first_term
);
   logic [TERMS_PER_CELL-1:0] live;

   if (TERMS_PER_CELL < 2) begin : g_bad_width
      $error("omc_term_gate: at least two terms per cell are required");
   end

   assign live       = terms & ~kill;
   assign first_term = live[0];
   assign sum_all    = |live;
   assign sum_tail   = |live[TERMS_PER_CELL-1:1];
endmodule

// File: rtl/omc_cell.sv
module omc_cell
   import omc_pkg::*;
#(
   parameter bit ASYNC_RESET = 1'b1,
   parameter bit RESET_Q     = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       oe,
   input  cell_mode_e mode,
   input  logic       pol,
   input  logic       sum_all,
   input  logic       sum_tail,
   input  logic       first_term,
   input  logic       pin_in,
   output logic       pin_out,
   output logic       pin_oe,
   output logic       fbk
);
   logic q;
   logic d_all;
   logic d_tail;
   logic load;

   assign d_all  = pol ? sum_all  : ~sum_all;
   assign d_tail = pol ? sum_tail : ~sum_tail;
   assign load   = (mode == CM_REG_OUT);

   if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= RESET_Q;
         else if (load) q <= d_all;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n)    q <= RESET_Q;
         else if (load) q <= d_all;
      end
   end

   always_comb begin
      case (mode)
         CM_COMB_OUT: begin
            pin_out = d_all;
            pin_oe  = 1'b1;
            fbk     = d_all;
         end
         CM_COMB_IO, CM_REG_IO: begin
            pin_out = d_tail;
            pin_oe  = first_term;
            fbk     = pin_in;
         end
         CM_REG_OUT: begin
            pin_out = ~q;
            pin_oe  = oe;
            fbk     = q;
         end
         default: begin
            pin_out = 1'b0;
            pin_oe  = 1'b0;
            fbk     = pin_in;
         end
      endcase
   end
endmodule

// File: rtl/omc_bank.sv
module omc_bank
   import omc_pkg::*;
#(
   parameter int NUM_CELLS      = 8,
   parameter int TERMS_PER_CELL = 8,
   parameter int KILL_HALF      = 32,
   parameter bit ASYNC_RESET    = 1'b1,
   localparam int NTERMS        = NUM_CELLS * TERMS_PER_CELL,
   localparam int ARCH_W        = 2 * KILL_HALF + 2 + 2 * NUM_CELLS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 oe,
   input  logic [NTERMS-1:0]    terms,
   input  logic [NUM_CELLS-1:0] pin_in,
   input  logic [ARCH_W-1:0]    arch,
   output logic [NUM_CELLS-1:0] pin_out,
   output logic [NUM_CELLS-1:0] pin_oe,
   output logic [NUM_CELLS-1:0] fbk
);
   logic [NTERMS-1:0]    term_kill;
   logic                 g_inhibit;
   logic                 g_mode;
   logic [NUM_CELLS-1:0] cell_mode_bit;
   logic [NUM_CELLS-1:0] cell_pol;

   if (NUM_CELLS < 1) begin : g_bad_cells
      $error("omc_bank: NUM_CELLS must be positive");
   end

   omc_cfg_split #(
      .NUM_CELLS(NUM_CELLS), .TERMS_PER_CELL(TERMS_PER_CELL), .KILL_HALF(KILL_HALF)
   ) u_split (
      .arch(arch), .term_kill(term_kill), .g_inhibit(g_inhibit), .g_mode(g_mode),
      .cell_mode_bit(cell_mode_bit), .cell_pol(cell_pol)
   );

   for (genvar n = 0; n < NUM_CELLS; n++) begin : g_cell
      logic       sum_all;
      logic       sum_tail;
      logic       first_term;
      cell_mode_e mode;

      assign mode = decode_mode(g_inhibit, g_mode, cell_mode_bit[n]);

      omc_term_gate #(.TERMS_PER_CELL(TERMS_PER_CELL)) u_gate (
         .terms(terms[n*TERMS_PER_CELL +: TERMS_PER_CELL]),
         .kill(term_kill[n*TERMS_PER_CELL +: TERMS_PER_CELL]),
         .sum_all(sum_all), .sum_tail(sum_tail), .first_term(first_term)
      );

      omc_cell #(.ASYNC_RESET(ASYNC_RESET), .RESET_Q(1'b0)) u_cell (
         .clk(clk), .rst_n(rst_n), .oe(oe), .mode(mode), .pol(cell_pol[n]),
         .sum_all(sum_all), .sum_tail(sum_tail), .first_term(first_term),
         .pin_in(pin_in[n]), .pin_out(pin_out[n]), .pin_oe(pin_oe[n]), .fbk(fbk[n])
      );
   end
endmodule

// File: rtl/omc_bank_chk.sv
module omc_bank_chk #(
   parameter int NUM_CELLS = 8,
   parameter int KILL_HALF = 32,
   localparam int ARCH_W   = 2 * KILL_HALF + 2 + 2 * NUM_CELLS
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 oe,
   input logic [NUM_CELLS-1:0] pin_in,
   input logic [ARCH_W-1:0]    arch,
   input logic [NUM_CELLS-1:0] pin_out,
   input logic [NUM_CELLS-1:0] pin_oe,
   input logic [NUM_CELLS-1:0] fbk
);
   logic cg;
   logic cm;
   assign cg = arch[KILL_HALF];
   assign cm = arch[KILL_HALF+1];

   for (genvar n = 0; n < NUM_CELLS; n++) begin : g_chk
      logic ca;
      assign ca = arch[KILL_HALF+2+n];

      // R4: input mode releases the pin and feeds it back
      p_input_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (cg && !cm && ca) |-> (!pin_oe[n] && fbk[n] == pin_in[n]));

      // R9: undecoded codes fall back to input behaviour
      p_other_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ((!cg && !cm) || (cg && cm && !ca)) |-> (!pin_oe[n] && fbk[n] == pin_in[n]));

      // R5: combinational output is always driven and feeds back its own value
      p_comb_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (cg && !cm && !ca) |-> (pin_oe[n] && fbk[n] == pin_out[n]));

      // R7: registered output drives the inverse of its feedback under oe
      p_reg_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!cg && cm && !ca) |-> (pin_oe[n] == oe && pin_out[n] == !fbk[n]));

      // R6 and R8: I/O modes feed back the pin
      p_io_feedback_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (cm && ca) |-> (fbk[n] == pin_in[n]));
   end
endmodule

bind omc_bank omc_bank_chk #(.NUM_CELLS(NUM_CELLS), .KILL_HALF(KILL_HALF)) u_chk (
   .clk(clk), .rst_n(rst_n), .oe(oe), .pin_in(pin_in), .arch(arch),
   .pin_out(pin_out), .pin_oe(pin_oe), .fbk(fbk)
);

// File: tb/omc_bank_test.sv
module omc_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        oe = 1'b1;
   logic [63:0] terms = '0;
   logic [7:0]  pin_in = '0;
   logic [81:0] arch = '0;
   logic [7:0]  pin_out, pin_oe, fbk;
   logic [7:0]  mq;
   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   omc_bank uut (
      .clk(clk), .rst_n(rst_n), .oe(oe), .terms(terms), .pin_in(pin_in),
      .arch(arch), .pin_out(pin_out), .pin_oe(pin_oe), .fbk(fbk)
   );

   function automatic logic [81:0] mk(input logic g, input logic m, input logic [7:0] a,
                                      input logic [7:0] p, input logic [63:0] kill);
      return {kill[63:32], p, a, m, g, kill[31:0]};
   endfunction

   // R1: term k is killed by bit k (k<32) or bit k+18
   function automatic logic live(input int k);
      logic kb;
      kb = (k < 32) ? arch[k] : arch[k+18];
      return terms[k] & ~kb;
   endfunction

   // 0 input, 1 comb out, 2 comb io, 3 reg out, 4 reg io
   function automatic int mmode(input int n);
      logic g, m, a;
      g = arch[32]; m = arch[33]; a = arch[34+n];
      if (g && !m && !a) return 1;
      if (g && m && a)   return 2;
      if (!g && m && !a) return 3;
      if (!g && m && a)  return 4;
      return 0;
   endfunction

   function automatic logic msum(input int n, input int from);
      logic s = 1'b0;
      for (int k = from; k < 8; k++) s = s | live(8*n + k);
      return arch[42+n] ? s : ~s;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) mq <= '0;
      else for (int n = 0; n < 8; n++) if (mmode(n) == 3) mq[n] <= msum(n, 0);
   end

   task automatic check(input string tag);
      for (int n = 0; n < 8; n++) begin
         logic eo, ee, ef;
         case (mmode(n))
            1: begin eo = msum(n, 0); ee = 1'b1; ef = eo; end
            2, 4: begin eo = msum(n, 1); ee = live(8*n); ef = pin_in[n]; end
            3: begin eo = ~mq[n]; ee = oe; ef = mq[n]; end
            default: begin eo = 1'b0; ee = 1'b0; ef = pin_in[n]; end
         endcase
         checks++;
         if (pin_out[n] !== eo || pin_oe[n] !== ee || fbk[n] !== ef) begin
            errors++;
            $display("FAIL %s cell %0d: out/oe/fbk=%b%b%b expected %b%b%b",
                     tag, n, pin_out[n], pin_oe[n], fbk[n], eo, ee, ef);
         end
      end
   endtask

   task automatic cyc(input string tag);
      #1 check(tag);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(64'd8 * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      arch = mk(1'b0, 1'b1, 8'h00, 8'hFF, 64'h0);
      terms = '1;
      @(negedge clk);
      #1 check("R10");
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R10");
      cyc("R7");
      // R5 / R3: combinational outputs with mixed polarity
      for (int i = 0; i < 12; i++) begin
         arch = mk(1'b1, 1'b0, 8'h00, 8'($urandom), 64'h0);
         terms = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         pin_in = 8'($urandom);
         cyc("R5/R3");
      end
      // R1: kill bits, one cell at a time and random masks
      for (int c = 0; c < 8; c++) begin
         terms = '1;
         arch = mk(1'b1, 1'b0, 8'h00, 8'hFF, 64'hFF << (8*c));
         cyc("R1");
         arch = mk(1'b1, 1'b0, 8'h00, 8'hFF, ~(64'h1 << (8*c + c)));
         terms = 64'h1 << (8*c + c);
         cyc("R1");
      end
      for (int i = 0; i < 10; i++) begin
         arch = mk(1'b1, 1'b1, 8'hFF, 8'($urandom), {$urandom, $urandom});
         terms = {$urandom, $urandom};
         cyc("R1/R6");
      end
      // R6: term 0 drives the enable
      for (int i = 0; i < 10; i++) begin
         arch = mk(1'b1, 1'b1, 8'hFF, 8'($urandom), 64'h0);
         terms = {$urandom, $urandom} & {$urandom, $urandom};
         pin_in = 8'($urandom);
         cyc("R6");
      end
      // R4: dedicated input
      for (int i = 0; i < 6; i++) begin
         arch = mk(1'b1, 1'b0, 8'hFF, 8'($urandom), 64'h0);
         terms = {$urandom, $urandom};
         pin_in = 8'($urandom);
         cyc("R4");
      end
      // R7: registered with oe toggling and R2 polarity positions
      for (int i = 0; i < 16; i++) begin
         arch = mk(1'b0, 1'b1, 8'h00, 8'($urandom), 64'h0);
         terms = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         oe = 1'($urandom);
         cyc("R7/R2");
      end
      // R8 / R11: mixed registered and I/O cells
      for (int i = 0; i < 16; i++) begin
         arch = mk(1'b0, 1'b1, 8'hA5 ^ 8'(i), 8'($urandom), 64'h0);
         terms = {$urandom, $urandom} & {$urandom, $urandom};
         pin_in = 8'($urandom);
         oe = 1'($urandom);
         cyc("R8/R11");
      end
      // R9: undecoded codes
      for (int i = 0; i < 12; i++) begin
         if (i % 2 == 0) arch = mk(1'b0, 1'b0, 8'($urandom), 8'($urandom), 64'h0);
         else            arch = mk(1'b1, 1'b1, 8'h00, 8'($urandom), 64'h0);
         terms = {$urandom, $urandom};
         pin_in = 8'($urandom);
         cyc("R9");
      end
      // R12: register holds outside registered mode
      oe = 1'b1;
      arch = mk(1'b0, 1'b1, 8'h00, 8'hFF, 64'h0);
      terms = '1;
      cyc("R12");
      cyc("R12");
      arch = mk(1'b1, 1'b0, 8'h00, 8'hFF, 64'h0);
      terms = '0;
      cyc("R12");
      cyc("R12");
      arch = mk(1'b0, 1'b1, 8'hFF, 8'hFF, 64'h0);
      cyc("R12");
      arch = mk(1'b0, 1'b1, 8'h00, 8'hFF, 64'h0);
      #1 begin
         checks++;
         if (fbk !== 8'hFF) begin
            errors++;
            $display("FAIL R12 held fbk=%h expected ff", fbk);
         end
      end
      check("R12");
      @(negedge clk);
      cyc("R12");
      // R10: asynchronous reset mid-run
      rst_n = 1'b0;
      #1 check("R10");
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R10");
      finish_run();
   end
endmodule